// File: doc/BRIEF.md
# Debounced Pin Interrupt Detector

This block watches an 8-bit input port and raises an interrupt request for chosen activity on each pin. Each pin is set to one of two trigger modes. In edge mode, a change in one or both directions sets the pin's flag. In level mode, the pin sets its flag for as long as it sits at the selected level. Edge mode can route the pin through a de-bounce filter. The filter accepts a new level only when two consecutive sample ticks both see it. The ticks come from a power-of-two divider of the system clock, or from an external tick input.

Each pin has a sticky pending flag. Software clears a flag by writing 1 to its bit. The interrupt output is high while any flag is set. Software programs the block through a small synchronous register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `pin_irq_detector`

## Requirements
- R1: The trigger-mode register at offset 0x18 selects the mode per pin in bits [7:0]: 0 selects edge triggering and 1 selects level triggering.
- R2: The trigger-enable register at offset 0x1C holds the falling/low enables in bits [7:0] and the rising/high enables in bits [23:16]. A read returns zeros in all other bits.
- R3: In edge mode with de-bounce off, a pin that goes from high to low with its falling enable set, or from low to high with its rising enable set, sets its flag. The flag becomes visible on the second rising clock edge after the pin changes.
- R4: In level mode, the pin is sampled once per clock. The pin sets its flag on every clock while it rests at its single enabled level (low with the falling enable, high with the rising enable). A cleared flag therefore comes back while that level persists.
- R5: In level mode, a pin with both its low and high enables set never sets its flag.
- R6: In edge mode with the pin's bit set in the de-bounce register at offset 0x14, an edge counts only when the new level is seen on two consecutive sample ticks. A pulse shorter than this sets no flag.
- R7: The de-bounce bit has no effect on a pin in level mode.
- R8: The tick-control register at offset 0x24 holds a period field k in bits [3:0] and a source bit in bit 4. With source 0, a tick occurs every 2^k clocks. With source 1, a tick occurs on each clock where ext_tick is high.
- R9: A read of the flag register at offset 0x20 returns 1 in bits [7:0] for each pending pin. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R10: When a new event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R11: irq is high exactly when at least one flag is set.
- R12: After reset, every register and flag reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 8 | Port input levels |
| ext_tick | input | 1 | External de-bounce sample tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq | output | 1 | Interrupt request, OR of all flags |

## Verification
The test drives the port with several patterns:
- Whole-port rising and falling steps in edge mode. These separate the rising enables from the falling enables.
- Split high/low levels in level mode, with clears issued while a level is still held. These separate sticky flags from live level conditions, and show whether set or clear wins when both hit a flag in the same cycle.
- Level mode with both enables set. This shows that such a pin is masked rather than armed.
- In de-bounce mode, a one-clock glitch, a long pulse and an early look at the flag. These tell filtered edges apart from raw ones.
- Holds with the external tick parked low and then pulsed, and a longer divider period. These tell the two tick sources and the period setting apart.

// File: rtl/pin_irq_detector.sv
module pin_irq_detector #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int PER_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              ext_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int RISE_LSB = 16;
  localparam int CNT_W    = 1 << PER_W;
  localparam logic [ADDR_W-1:0] A_DBEN = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_TICK = ADDR_W'('h24);

  logic [NPINS-1:0] mode_q, dben_q, fall_en, rise_en, flag_q;
  logic [NPINS-1:0] smp_q, prev_q, hold_q, deb_q;
  logic [PER_W-1:0] per_q;
  logic             src_q;
  logic [CNT_W-1:0] div_q, div_mask;
  logic             tick;
  logic [NPINS-1:0] lvl_evt, raw_evt, deb_evt, evt, clr, agree;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign div_mask = (CNT_W'(1) << per_q) - CNT_W'(1);
  assign tick     = src_q ? ext_tick : ((div_q & div_mask) == div_mask);
  assign agree    = ~(hold_q ^ smp_q);

  assign lvl_evt = mode_q & (fall_en ^ rise_en) &
                   ((fall_en & ~smp_q) | (rise_en & smp_q));
  assign raw_evt = ~mode_q & ~dben_q &
                   ((fall_en & prev_q & ~smp_q) | (rise_en & ~prev_q & smp_q));
  assign deb_evt = ~mode_q & dben_q & {NPINS{tick}} & agree &
                   ((fall_en & deb_q & ~smp_q) | (rise_en & ~deb_q & smp_q));
  assign evt     = lvl_evt | raw_evt | deb_evt;

  assign clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata[NPINS-1:0] : '0;
  assign irq = |flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      dben_q  <= '0;
      fall_en <= '0;
      rise_en <= '0;
      flag_q  <= '0;
      per_q   <= '0;
      src_q   <= 1'b0;
      smp_q   <= '0;
      prev_q  <= '0;
      hold_q  <= '0;
      deb_q   <= '0;
      div_q   <= '0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_DBEN: dben_q <= bus_wdata[NPINS-1:0];
          A_MODE: mode_q <= bus_wdata[NPINS-1:0];
          A_EN: begin
            fall_en <= bus_wdata[NPINS-1:0];
            rise_en <= bus_wdata[RISE_LSB +: NPINS];
          end
          A_TICK: begin
            per_q <= bus_wdata[PER_W-1:0];
            src_q <= bus_wdata[PER_W];
          end
          default: ;
        endcase
      end
      flag_q <= (flag_q & ~clr) | evt;
      smp_q  <= pin_in;
      prev_q <= smp_q;
      div_q  <= div_q + CNT_W'(1);
      if (tick) begin
        hold_q <= smp_q;
        deb_q  <= (agree & smp_q) | (~agree & deb_q);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DBEN: bus_rdata[NPINS-1:0] = dben_q;
      A_MODE: bus_rdata[NPINS-1:0] = mode_q;
      A_EN: begin
        bus_rdata[NPINS-1:0]          = fall_en;
        bus_rdata[RISE_LSB +: NPINS]  = rise_en;
      end
      A_FLAG: bus_rdata[NPINS-1:0] = flag_q;
      A_TICK: begin
        bus_rdata[PER_W-1:0] = per_q;
        bus_rdata[PER_W]     = src_q;
      end
      default: ;
    endcase
  end

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(clr & ~evt)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(evt)) == $past(evt)));

  // R5
  both_level_mute_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & $past(mode_q & fall_en & rise_en)) == '0));

  // R6
  deb_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((flag_q & ~$past(flag_q) & $past(~mode_q & dben_q)) == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(evt) != '0);
endmodule

// File: tb/test_pin_irq_detector.sv
module test_pin_irq_detector;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_DBEN = 6'h14, A_MODE = 6'h18, A_EN = 6'h1C,
                         A_FLAG = 6'h20, A_TICK = 6'h24;

  logic clk = 0, rst = 1, ext_tick = 0, bus_we = 0, irq;
  logic [7:0] pin_in = 0;
  logic [5:0] bus_addr = A_FLAG;
  logic [31:0] bus_wdata = 0, bus_rdata;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R12";

  pin_irq_detector i_pin_irq_detector (
    .clk(clk), .rst(rst), .pin_in(pin_in), .ext_tick(ext_tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] m_s, m_p, m_h, m_d, m_flag, m_mode, m_db, m_fe, m_re;
  logic [3:0] m_k;
  logic m_src;
  int m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      {m_s, m_p, m_h, m_d, m_flag, m_mode, m_db, m_fe, m_re} = '0;
      m_k = 0; m_src = 0; m_cnt = 0;
    end else begin
      bit tk;
      logic [7:0] nf;
      int per;
      per = 1 << m_k;
      tk = m_src ? ext_tick : ((m_cnt % per) == per - 1);
      for (int i = 0; i < 8; i++) begin
        bit hit;
        hit = 0;
        if (m_mode[i]) begin
          if (m_fe[i] != m_re[i]) hit = m_fe[i] ? !m_s[i] : m_s[i];
        end else if (m_db[i]) begin
          if (tk && m_h[i] == m_s[i] && m_d[i] != m_s[i]) hit = m_s[i] ? m_re[i] : m_fe[i];
        end else if (m_p[i] != m_s[i]) begin
          hit = m_s[i] ? m_re[i] : m_fe[i];
        end
        nf[i] = hit || (m_flag[i] && !(bus_we && bus_addr == A_FLAG && bus_wdata[i]));
      end
      m_flag = nf;
      m_p = m_s;
      if (tk) begin
        for (int i = 0; i < 8; i++) if (m_h[i] == m_s[i]) m_d[i] = m_s[i];
        m_h = m_s;
      end
      m_s = pin_in;
      m_cnt = (m_cnt + 1) % 65536;
      if (bus_we) begin
        case (bus_addr)
          A_DBEN: m_db = bus_wdata[7:0];
          A_MODE: m_mode = bus_wdata[7:0];
          A_EN: begin m_fe = bus_wdata[7:0]; m_re = bus_wdata[23:16]; end
          A_TICK: begin m_k = bus_wdata[3:0]; m_src = bus_wdata[4]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    case (a)
      A_DBEN: return {24'h0, m_db};
      A_MODE: return {24'h0, m_mode};
      A_EN:   return {8'h0, m_re, 8'h0, m_fe};
      A_FLAG: return {24'h0, m_flag};
      A_TICK: return {27'h0, m_src, m_k};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      chk("R11", {31'h0, irq}, {31'h0, m_flag != 0});
      chk(cur_req, bus_rdata, exp_rd(bus_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = A_FLAG; bus_wdata = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    wait_n(3);
    rst = 0;
    // R12 reset state
    rd_chk("R12", A_DBEN, 0);
    rd_chk("R12", A_MODE, 0);
    rd_chk("R12", A_EN, 0);
    rd_chk("R12", A_FLAG, 0);
    rd_chk("R12", A_TICK, 0);
    chk("R12", {31'h0, irq}, 0);

    // R3 / R2 raw edges
    cur_req = "R3";
    wr(A_EN, 32'h00F0_00FF);
    rd_chk("R2", A_EN, 32'h00F0_00FF);
    set_pins(8'hFF);
    wait_n(3);
    rd_chk("R3", A_FLAG, 32'hF0);
    cur_req = "R9";
    wr(A_FLAG, 32'hFF);
    rd_chk("R9", A_FLAG, 0);
    cur_req = "R3";
    set_pins(8'h00);
    wait_n(3);
    rd_chk("R3", A_FLAG, 32'hFF);
    chk("R11", {31'h0, irq}, 1);
    cur_req = "R9";
    wr(A_FLAG, 32'h0F);
    rd_chk("R9", A_FLAG, 32'hF0);
    wr(A_FLAG, 32'h00);
    rd_chk("R9", A_FLAG, 32'hF0);
    wr(A_FLAG, 32'hFF);
    rd_chk("R11", A_FLAG, 0);
    chk("R11", {31'h0, irq}, 0);
    cur_req = "R3";
    set_pins(8'h55); wait_n(2);
    set_pins(8'hAA); wait_n(2);
    set_pins(8'h00); wait_n(3);
    wr(A_FLAG, 32'hFF);

    // R1 / R4 level mode
    cur_req = "R1";
    wr(A_MODE, 32'hFF);
    rd_chk("R1", A_MODE, 32'hFF);
    cur_req = "R4";
    wr(A_EN, 32'h00F0_000F);
    wait_n(3);
    rd_chk("R4", A_FLAG, 32'h0F);
    cur_req = "R10";
    wr(A_FLAG, 32'hFF);
    #1 chk("R10", bus_rdata, 32'h0F);
    cur_req = "R4";
    set_pins(8'hFF);
    wait_n(3);
    rd_chk("R4", A_FLAG, 32'hFF);
    wr(A_FLAG, 32'h0F);
    wait_n(1);
    rd_chk("R4", A_FLAG, 32'hF0);

    // R5 both enables in level mode
    cur_req = "R5";
    wr(A_EN, 32'h00FF_00FF);
    wr(A_FLAG, 32'hFF);
    wait_n(3);
    rd_chk("R5", A_FLAG, 0);
    set_pins(8'h00);
    wait_n(4);
    rd_chk("R5", A_FLAG, 0);

    // R7 de-bounce bit ignored in level mode
    cur_req = "R7";
    wr(A_TICK, 32'h0F);
    wr(A_DBEN, 32'hFF);
    wr(A_EN, 32'h00F0_000F);
    set_pins(8'hF0);
    wr(A_FLAG, 32'hFF);
    wait_n(3);
    rd_chk("R7", A_FLAG, 32'hFF);

    // R6 de-bounced edges, tick every 4 clocks
    cur_req = "R6";
    wr(A_TICK, 32'h02);
    wr(A_MODE, 32'h00);
    wr(A_EN, 32'h00FF_00FF);
    set_pins(8'h00);
    wait_n(12);
    wr(A_FLAG, 32'hFF);
    wait_n(2);
    rd_chk("R6", A_FLAG, 0);
    set_pins(8'h01);
    set_pins(8'h00);
    wait_n(12);
    rd_chk("R6", A_FLAG, 0);
    set_pins(8'h02);
    wait_n(2);
    rd_chk("R6", A_FLAG, 0);
    wait_n(10);
    rd_chk("R6", A_FLAG, 32'h02);
    set_pins(8'h00);
    wait_n(12);
    wr(A_FLAG, 32'hFF);

    // R8 external tick source
    cur_req = "R8";
    wr(A_TICK, 32'h10);
    rd_chk("R8", A_TICK, 32'h10);
    set_pins(8'h04);
    wait_n(20);
    rd_chk("R8", A_FLAG, 0);
    @(negedge clk) ext_tick = 1;
    @(negedge clk) ext_tick = 0;
    @(negedge clk) ext_tick = 1;
    @(negedge clk) ext_tick = 0;
    wait_n(2);
    rd_chk("R8", A_FLAG, 32'h04);
    // longer internal period
    wr(A_TICK, 32'h03);
    wr(A_FLAG, 32'hFF);
    for (int n = 0; n < 6; n++) begin
      set_pins(8'h0F ^ pin_in);
      wait_n(5 + 3 * n);
    end
    set_pins(8'h00);
    wait_n(30);
    wr(A_FLAG, 32'hFF);
    rd_chk("R8", A_FLAG, 0);

    wait_n(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule